// File: doc/BRIEF.md
# Interrupt Controller Programming Sequencer

This block is the byte-wide register front end of an eight-line interrupt controller. A processor reaches it through two addresses. Writes to address 0 either begin the initialization sequence or issue a run-time command. Writes to address 1 either feed the next byte of the initialization sequence or, once the sequence is over, load the interrupt mask. Reads return the pending-request register, the in-service register or the mask. After a poll command, the next read returns a poll result instead.

The block does not hold the request or in-service state and does not arbitrate between lines. A separate priority resolver supplies the request and in-service registers and the current winning line. In return it takes the configuration outputs, a clear strobe at initialization, command strobes for end-of-interrupt and priority commands, and acknowledge strobes. An acknowledge can come from a poll read or from the processor's interrupt-acknowledge cycle. The acknowledge cycle also returns an interrupt vector: the programmed base plus the winning line.

Every output is registered. A bus access in one cycle shows its effect on the outputs in the next cycle.

Top module: `pic_prog_seq`

## Requirements
- R1: After reset every output is 0, and the initialization step is idle.
- R2: An address-0 write with bit 4 set does the following. It pulses init_clear for one cycle. It clears the mask, poll, read-select, special-mask, rotate-on-auto-EOI, special-nested, auto-EOI and vector base. It raises init_busy. It latches three bits of the byte: bit 0 (fourth step wanted), bit 1 (cfg_single) and bit 3 (cfg_level).
- R3: In the base step, an address-1 write sets cfg_vbase to the byte AND 0xF8. Without single mode, the sequence moves to the cascade step. In single mode it moves to the mode step if the fourth step was wanted, and otherwise it ends (init_busy falls).
- R4: The cascade step takes one address-1 byte and ignores its value. It then moves to the mode step if the fourth step was wanted, and otherwise ends. The mode step sets cfg_sfnm from bit 4 and cfg_aeoi from bit 1, then ends.
- R5: With no initialization in progress, an address-1 write loads mask_out with the byte. Address-1 writes during initialization never change mask_out.
- R6: An address-0 write with bit 4 clear and bit 3 set is a mode command. If bit 2 is set, it sets poll mode. If bit 1 is set, it sets read-select from bit 0. If bit 6 is set, it sets cfg_smask from bit 5. Cleared enable bits leave the matching state unchanged.
- R7: Any other address-0 write is an operation command with code bits 7:5. Codes 0 and 4 set cfg_rot_aeoi to bit 7. Codes 1, 3, 5, 6 and 7 pulse cmd_strobe for one cycle, with cmd_code set to the code and cmd_line set to bits 2:0. Code 2 has no effect.
- R8: Outside poll mode, a read raises bus_rvalid one cycle later. Address 0 returns isr_in when read-select is 1 and irr_in when it is 0. Address 1 returns mask_out.
- R9: In poll mode, a read at either address returns 0x80 OR win_line and pulses ack_strobe with ack_line = win_line when win_valid is 1. When win_valid is 0 it returns 0 and raises no acknowledge. Poll mode then ends.
- R10: An inta pulse raises vector_valid one cycle later. The vector is cfg_vbase + win_line, with an acknowledge of that line, when win_valid is 1. It is cfg_vbase + 7, with no acknowledge, when win_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | Register address (0 or 1) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| irr_in | input | 8 | Pending-request register from the resolver |
| isr_in | input | 8 | In-service register from the resolver |
| win_valid | input | 1 | Resolver has a line to grant |
| win_line | input | 3 | Winning line |
| inta | input | 1 | Processor interrupt-acknowledge cycle |
| vector_out | output | 8 | Interrupt vector |
| vector_valid | output | 1 | Vector valid |
| ack_strobe | output | 1 | Acknowledge to the resolver |
| ack_line | output | 3 | Line being acknowledged |
| init_clear | output | 1 | Clear pulse to the resolver at initialization |
| init_busy | output | 1 | Initialization sequence in progress |
| cmd_strobe | output | 1 | End-of-interrupt or priority command pulse |
| cmd_code | output | 3 | Command code |
| cmd_line | output | 3 | Line operand of the command |
| cfg_level | output | 1 | Level-triggered mode for all lines |
| cfg_single | output | 1 | Single-controller mode |
| cfg_sfnm | output | 1 | Special fully nested mode |
| cfg_aeoi | output | 1 | Automatic end-of-interrupt |
| cfg_rot_aeoi | output | 1 | Rotate on automatic end-of-interrupt |
| cfg_smask | output | 1 | Special mask mode |
| cfg_vbase | output | 8 | Vector base |
| mask_out | output | 8 | Interrupt mask register |

## Verification
The assertions assume that at most one of bus_wr, bus_rd and inta is high in any cycle, and one of them checks this at the inputs. Under that assumption, a mask load, an initialization reset or a change of vector base can never coincide with a read or a vector return. The bench draws a single operation per cycle, both in its directed sequences and in its random phase, so the stimulus never breaks the assumption. The resolver inputs are driven freely, because the block only samples them during reads and acknowledge cycles.

// File: rtl/pic_seq_pkg.sv
package pic_seq_pkg;
    localparam int DATA_W = 8;
    localparam int LINE_W = 3;
    localparam int LINES  = 1 << LINE_W;
    localparam int CODE_W = 3;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [CODE_W-1:0] code_t;

    localparam line_t SPURIOUS_LINE = line_t'(LINES - 1);
    localparam byte_t VBASE_KEEP    = byte_t'(8'hF8);

    // address-0 byte fields
    localparam int B_INIT     = 4;
    localparam int B_MODE     = 3;
    localparam int B_POLL     = 2;
    localparam int B_RSEL_EN  = 1;
    localparam int B_RSEL     = 0;
    localparam int B_SMASK_EN = 6;
    localparam int B_SMASK    = 5;
    localparam int B_ROT      = 7;
    localparam int B_CODE_LO  = 5;
    // initialization byte fields
    localparam int B_NEED4    = 0;
    localparam int B_SINGLE   = 1;
    localparam int B_LEVEL    = 3;
    localparam int B_SFNM     = 4;
    localparam int B_AEOI     = 1;

    localparam code_t CODE_ROT_CLR = 3'd0;
    localparam code_t CODE_NOP     = 3'd2;
    localparam code_t CODE_ROT_SET = 3'd4;

    typedef enum logic [1:0] {
        STEP_IDLE = 2'd0,
        STEP_BASE = 2'd1,
        STEP_CASC = 2'd2,
        STEP_MODE = 2'd3
    } init_step_e;

    typedef struct packed {
        init_step_e step;
        logic       need4;
        logic       single;
        logic       level;
        logic       sfnm;
        logic       aeoi;
        logic       clr;
        byte_t      vbase;
    } init_state_t;

    typedef struct packed {
        logic  poll;
        logic  rsel;
        logic  smask;
        logic  rot;
        logic  stb;
        code_t code;
        line_t line;
    } cmd_state_t;

    typedef struct packed {
        byte_t rdata;
        logic  rvalid;
        logic  ack;
        line_t ack_line;
        byte_t vec;
        logic  vec_valid;
    } rd_state_t;
endpackage

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
    import pic_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_cmd,
    input  logic        step_wr,
    input  byte_t       wdata,
    output init_state_t st,
    output logic        mask_wr
);
    init_state_t q, d;

    always_comb begin
        d     = q;
        d.clr = 1'b0;
        if (init_cmd) begin
            d        = '0;
            d.step   = STEP_BASE;
            d.need4  = wdata[B_NEED4];
            d.single = wdata[B_SINGLE];
            d.level  = wdata[B_LEVEL];
            d.clr    = 1'b1;
        end else if (step_wr) begin
            unique case (q.step)
                STEP_BASE: begin
                    d.vbase = wdata & VBASE_KEEP;
                    if (!q.single)
                        d.step = STEP_CASC;
                    else if (q.need4)
                        d.step = STEP_MODE;
                    else
                        d.step = STEP_IDLE;
                end
                STEP_CASC: d.step = q.need4 ? STEP_MODE : STEP_IDLE;
                STEP_MODE: begin
                    d.sfnm = wdata[B_SFNM];
                    d.aeoi = wdata[B_AEOI];
                    d.step = STEP_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign st      = q;
    assign mask_wr = step_wr && (q.step == STEP_IDLE);
endmodule

// File: rtl/pic_cmd_dec.sv
module pic_cmd_dec
    import pic_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr0,
    input  byte_t      wdata,
    input  logic       poll_take,
    output cmd_state_t st
);
    cmd_state_t q, d;
    code_t      code;

    assign code = wdata[B_CODE_LO +: CODE_W];

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        if (poll_take) d.poll = 1'b0;
        if (wr0) begin
            if (wdata[B_INIT]) begin
                d.poll  = 1'b0;
                d.rsel  = 1'b0;
                d.smask = 1'b0;
                d.rot   = 1'b0;
            end else if (wdata[B_MODE]) begin
                if (wdata[B_POLL])     d.poll  = 1'b1;
                if (wdata[B_RSEL_EN])  d.rsel  = wdata[B_RSEL];
                if (wdata[B_SMASK_EN]) d.smask = wdata[B_SMASK];
            end else begin
                if (code == CODE_ROT_CLR || code == CODE_ROT_SET) begin
                    d.rot = wdata[B_ROT];
                end else if (code != CODE_NOP) begin
                    d.stb  = 1'b1;
                    d.code = code;
                    d.line = wdata[LINE_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign st = q;
endmodule

// File: rtl/pic_rd_path.sv
module pic_rd_path
    import pic_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bus_rd,
    input  logic      bus_addr,
    input  logic      poll,
    input  logic      rsel,
    input  byte_t     irr,
    input  byte_t     isr,
    input  byte_t     mask,
    input  byte_t     vbase,
    input  logic      win_valid,
    input  line_t     win_line,
    input  logic      inta,
    output logic      poll_take,
    output rd_state_t st
);
    rd_state_t q, d;

    assign poll_take = bus_rd && poll;

    always_comb begin
        d           = q;
        d.rvalid    = bus_rd;
        d.vec_valid = inta;
        d.ack       = 1'b0;
        if (bus_rd) begin
            if (poll) begin
                d.rdata = '0;
                if (win_valid) begin
                    d.rdata[DATA_W-1]   = 1'b1;
                    d.rdata[LINE_W-1:0] = win_line;
                    d.ack               = 1'b1;
                    d.ack_line          = win_line;
                end
            end else if (bus_addr) begin
                d.rdata = mask;
            end else begin
                d.rdata = rsel ? isr : irr;
            end
        end
        if (inta) begin
            d.vec = vbase + byte_t'(win_valid ? win_line : SPURIOUS_LINE);
            if (win_valid) begin
                d.ack      = 1'b1;
                d.ack_line = win_line;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign st = q;
endmodule

// File: rtl/pic_prog_seq.sv
module pic_prog_seq
    import pic_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       bus_rvalid,
    input  logic [7:0] irr_in,
    input  logic [7:0] isr_in,
    input  logic       win_valid,
    input  logic [2:0] win_line,
    input  logic       inta,
    output logic [7:0] vector_out,
    output logic       vector_valid,
    output logic       ack_strobe,
    output logic [2:0] ack_line,
    output logic       init_clear,
    output logic       init_busy,
    output logic       cmd_strobe,
    output logic [2:0] cmd_code,
    output logic [2:0] cmd_line,
    output logic       cfg_level,
    output logic       cfg_single,
    output logic       cfg_sfnm,
    output logic       cfg_aeoi,
    output logic       cfg_rot_aeoi,
    output logic       cfg_smask,
    output logic [7:0] cfg_vbase,
    output logic [7:0] mask_out
);
    logic        wr0, init_cmd, step_wr, mask_wr, poll_take;
    init_state_t ini;
    cmd_state_t  cmd;
    rd_state_t   rdp;
    byte_t       mask_d, mask_q;

    assign wr0      = bus_wr && !bus_addr;
    assign init_cmd = wr0 && bus_wdata[B_INIT];
    assign step_wr  = bus_wr && bus_addr;

    pic_init_fsm u_init (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_cmd(init_cmd),
        .step_wr (step_wr),
        .wdata   (bus_wdata),
        .st      (ini),
        .mask_wr (mask_wr)
    );

    pic_cmd_dec u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr0      (wr0),
        .wdata    (bus_wdata),
        .poll_take(poll_take),
        .st       (cmd)
    );

    pic_rd_path u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .poll     (cmd.poll),
        .rsel     (cmd.rsel),
        .irr      (irr_in),
        .isr      (isr_in),
        .mask     (mask_q),
        .vbase    (ini.vbase),
        .win_valid(win_valid),
        .win_line (win_line),
        .inta     (inta),
        .poll_take(poll_take),
        .st       (rdp)
    );

    always_comb begin
        mask_d = mask_q;
        if (init_cmd)     mask_d = '0;
        else if (mask_wr) mask_d = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign bus_rdata    = rdp.rdata;
    assign bus_rvalid   = rdp.rvalid;
    assign vector_out   = rdp.vec;
    assign vector_valid = rdp.vec_valid;
    assign ack_strobe   = rdp.ack;
    assign ack_line     = rdp.ack_line;
    assign init_clear   = ini.clr;
    assign init_busy    = (ini.step != STEP_IDLE);
    assign cmd_strobe   = cmd.stb;
    assign cmd_code     = cmd.code;
    assign cmd_line     = cmd.line;
    assign cfg_level    = ini.level;
    assign cfg_single   = ini.single;
    assign cfg_sfnm     = ini.sfnm;
    assign cfg_aeoi     = ini.aeoi;
    assign cfg_rot_aeoi = cmd.rot;
    assign cfg_smask    = cmd.smask;
    assign cfg_vbase    = ini.vbase;
    assign mask_out     = mask_q;
endmodule

// File: rtl/pic_prog_seq_chk.sv
module pic_prog_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       inta,
    input logic       bus_rvalid,
    input logic [7:0] vector_out,
    input logic       vector_valid,
    input logic       ack_strobe,
    input logic       init_clear,
    input logic       init_busy,
    input logic       cmd_strobe,
    input logic [2:0] cmd_code,
    input logic       cfg_rot_aeoi,
    input logic       cfg_smask,
    input logic [7:0] cfg_vbase,
    input logic [7:0] mask_out
);
    // input assumption: one access per cycle (R8 reads rely on it)
    p_single_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({bus_wr, bus_rd, inta}) <= 1);

    p_init_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_clear |-> (mask_out == 8'h00 && init_busy && !cfg_smask && !cfg_rot_aeoi));

    p_init_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (init_busy && $past(init_busy)) |-> $stable(mask_out));

    p_cmd_codes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |-> (cmd_code != 3'd0 && cmd_code != 3'd2 && cmd_code != 3'd4));

    p_read_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    p_ack_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_strobe |-> $past(bus_rd || inta));

    p_vector_base_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vector_valid |-> (vector_out[7:3] == cfg_vbase[7:3]));
endmodule

bind pic_prog_seq pic_prog_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .inta        (inta),
    .bus_rvalid  (bus_rvalid),
    .vector_out  (vector_out),
    .vector_valid(vector_valid),
    .ack_strobe  (ack_strobe),
    .init_clear  (init_clear),
    .init_busy   (init_busy),
    .cmd_strobe  (cmd_strobe),
    .cmd_code    (cmd_code),
    .cfg_rot_aeoi(cfg_rot_aeoi),
    .cfg_smask   (cfg_smask),
    .cfg_vbase   (cfg_vbase),
    .mask_out    (mask_out)
);

// File: tb/pic_prog_seq_tb.sv
module pic_prog_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0, inta = 1'b0;
    logic [7:0] bus_wdata = 8'h00, irr_in = 8'h00, isr_in = 8'h00;
    logic       win_valid = 1'b0;
    logic [2:0] win_line = 3'd0;
    logic [7:0] bus_rdata, vector_out, cfg_vbase, mask_out;
    logic       bus_rvalid, vector_valid, ack_strobe, init_clear, init_busy, cmd_strobe;
    logic [2:0] ack_line, cmd_code, cmd_line;
    logic       cfg_level, cfg_single, cfg_sfnm, cfg_aeoi, cfg_rot_aeoi, cfg_smask;

    always #4 clk = ~clk;

    pic_prog_seq u_dut (.*);

    int n_run = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    // behavioural reference state
    int         m_step;
    bit         m_need4, m_single, m_level, m_sfnm, m_aeoi, m_poll, m_rsel, m_smask, m_rot;
    bit         m_clr, m_stb, m_rvalid, m_ack, m_vvalid, m_poll_rd;
    logic [7:0] m_vbase, m_mask, m_rdata, m_vec;
    logic [2:0] m_code, m_line, m_ack_line;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_step = 0; m_need4 = 0; m_single = 0; m_level = 0; m_sfnm = 0; m_aeoi = 0;
            m_poll = 0; m_rsel = 0; m_smask = 0; m_rot = 0; m_clr = 0; m_stb = 0;
            m_rvalid = 0; m_ack = 0; m_vvalid = 0; m_poll_rd = 0;
            m_vbase = 0; m_mask = 0; m_rdata = 0; m_vec = 0;
            m_code = 0; m_line = 0; m_ack_line = 0;
        end else begin
            m_clr = 0; m_stb = 0; m_rvalid = 0; m_ack = 0; m_vvalid = 0;
            if (bus_wr && !bus_addr) begin
                if (bus_wdata[4]) begin
                    m_mask = 0; m_poll = 0; m_rsel = 0; m_smask = 0; m_rot = 0;
                    m_sfnm = 0; m_aeoi = 0; m_vbase = 0; m_clr = 1; m_step = 1;
                    m_need4 = bus_wdata[0]; m_single = bus_wdata[1]; m_level = bus_wdata[3];
                end else if (bus_wdata[3]) begin
                    if (bus_wdata[2]) m_poll = 1;
                    if (bus_wdata[1]) m_rsel = bus_wdata[0];
                    if (bus_wdata[6]) m_smask = bus_wdata[5];
                end else begin
                    case (int'(bus_wdata[7:5]))
                        0, 4: m_rot = bus_wdata[7];
                        2: ;
                        default: begin
                            m_stb = 1; m_code = bus_wdata[7:5]; m_line = bus_wdata[2:0];
                        end
                    endcase
                end
            end else if (bus_wr) begin
                if (m_step == 0) m_mask = bus_wdata;
                else if (m_step == 1) begin
                    m_vbase = bus_wdata & 8'hF8;
                    m_step = !m_single ? 2 : (m_need4 ? 3 : 0);
                end else if (m_step == 2) m_step = m_need4 ? 3 : 0;
                else begin
                    m_sfnm = bus_wdata[4]; m_aeoi = bus_wdata[1]; m_step = 0;
                end
            end
            if (bus_rd) begin
                m_rvalid = 1;
                m_poll_rd = m_poll;
                if (m_poll) begin
                    m_poll = 0;
                    if (win_valid) begin
                        m_rdata = {5'b10000, win_line}; m_ack = 1; m_ack_line = win_line;
                    end else m_rdata = 0;
                end else m_rdata = bus_addr ? m_mask : (m_rsel ? isr_in : irr_in);
            end
            if (inta) begin
                m_vvalid = 1;
                m_vec = m_vbase + (win_valid ? {5'd0, win_line} : 8'd7);
                if (win_valid) begin m_ack = 1; m_ack_line = win_line; end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 init_clear", init_clear, m_clr);
            chk("R2 cfg_level", cfg_level, m_level);
            chk("R2 cfg_single", cfg_single, m_single);
            chk("R3 init_busy", init_busy, m_step != 0);
            chk("R3 cfg_vbase", cfg_vbase, m_vbase);
            chk("R4 cfg_sfnm", cfg_sfnm, m_sfnm);
            chk("R4 cfg_aeoi", cfg_aeoi, m_aeoi);
            chk("R5 mask_out", mask_out, m_mask);
            chk("R6 cfg_smask", cfg_smask, m_smask);
            chk("R7 cfg_rot_aeoi", cfg_rot_aeoi, m_rot);
            chk("R7 cmd_strobe", cmd_strobe, m_stb);
            chk("R7 cmd_code", cmd_code, m_code);
            chk("R7 cmd_line", cmd_line, m_line);
            chk("R8 bus_rvalid", bus_rvalid, m_rvalid);
            chk(m_poll_rd ? "R9 poll rdata" : "R8 rdata", bus_rdata, m_rdata);
            chk("R9 ack_strobe", ack_strobe, m_ack);
            chk("R9 ack_line", ack_line, m_ack_line);
            chk("R10 vector_valid", vector_valid, m_vvalid);
            chk("R10 vector_out", vector_out, m_vec);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
            summary();
            $finish;
        end
    end

    task automatic wr(input logic a, input logic [7:0] v);
        bus_wr = 1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic a);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic ack(input logic v, input logic [2:0] l);
        win_valid = v; win_line = l; inta = 1;
        @(negedge clk);
        inta = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 mask_out", mask_out, 8'h00);
        chk("R1 init_busy", init_busy, 1'b0);
        chk("R1 strobes", {bus_rvalid, vector_valid, ack_strobe, init_clear, cmd_strobe}, 5'd0);
        chk("R1 config", {cfg_level, cfg_single, cfg_sfnm, cfg_aeoi, cfg_rot_aeoi, cfg_smask, cfg_vbase}, 14'd0);
        rst_n = 1;
        @(negedge clk);
        // R2..R4: cascaded init with fourth step
        wr(0, 8'h11); wr(1, 8'h27); wr(1, 8'h04); wr(1, 8'h13);
        // R5, R8
        wr(1, 8'hA5); rd(1);
        irr_in = 8'h3C; isr_in = 8'h81;
        rd(0); wr(0, 8'h0B); rd(0); wr(0, 8'h0A); rd(0);
        // R6
        wr(0, 8'h68); wr(0, 8'h28); wr(0, 8'h48);
        // R9 poll with and without a winner
        win_valid = 1; win_line = 3'd5;
        wr(0, 8'h0C); rd(1); rd(1);
        win_valid = 0;
        wr(0, 8'h0C); rd(0); rd(0);
        // R7 all codes
        wr(0, 8'h20); wr(0, 8'h63); wr(0, 8'hA0); wr(0, 8'hC7);
        wr(0, 8'hE2); wr(0, 8'h40); wr(0, 8'h80); wr(0, 8'h00); wr(0, 8'h80);
        // R10
        ack(1, 3'd3); ack(0, 3'd1);
        // R2 clears, single mode with fourth step, mask ignored during init (R5)
        wr(0, 8'h68); wr(0, 8'h1B); wr(1, 8'h4F); wr(1, 8'h02); wr(1, 8'h77);
        ack(0, 3'd0);
        // single, no fourth step; cascade, no fourth step
        wr(0, 8'h12); wr(1, 8'hFF); wr(1, 8'h3C);
        wr(0, 8'h10); wr(1, 8'h08); wr(1, 8'h55); wr(1, 8'h99);
        // random phase: one access per cycle
        for (int i = 0; i < 3000; i++) begin
            int op;
            op = $urandom_range(0, 5);
            irr_in = 8'($urandom); isr_in = 8'($urandom);
            win_valid = 1'($urandom); win_line = 3'($urandom);
            case (op)
                0: wr(0, 8'($urandom) & ((($urandom_range(0, 3)) == 0) ? 8'hFF : 8'hEF));
                1: wr(1, 8'($urandom));
                2: rd(1'($urandom));
                3: begin inta = 1; @(negedge clk); inta = 0; end
                4: wr(0, 8'h0C);
                default: @(negedge clk);
            endcase
        end
        repeat (3) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule